// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Cell Group

This block is the boundary-scan logic for a row of bidirectional user pins. For each pin it has three capture/shift stages, one each for the pin input, the output enable and the output data, plus three update registers behind them. It sits between the core logic (core output, core output enable, core input) and the pad (pad output, pad output enable, pad input). The stages of all pins form one serial path from `scanIn` to `scanOut`, so the group drops into a longer chain between the test data input and output of the chip.

All strobes are synchronous enables on one clock. `clockEn` advances the capture stages. Depending on `shiftSel`, they either load their parallel inputs or move the chain by one bit. `updateEn` copies the stages into the update registers. Instruction decode supplies `modeSel` and `highZ`. With `modeSel` low, every pad-side and core-side output carries its functional signal. With it high, they carry the update registers. `highZ` turns every pad driver off whatever the other controls say. Only user I/O pins get a cell. Supply pins are never part of the chain.

Top module: `bscanPinGroup`

## Requirements
- R1: After reset all capture and update bits are 0. So with `modeSel`=1 and `highZ`=0, `padOut`, `padOe`, `coreIn` and `scanOut` all read 0.
- R2: On a clock edge with `clockEn`=1 and `shiftSel`=0, each pin's stages load `padIn[i]` (input stage), `coreOe[i]` (enable stage) and `coreOut[i]` (output stage).
- R3: On a clock edge with `clockEn`=1 and `shiftSel`=1, the chain moves one place toward `scanOut`. The stage order from `scanIn` is pin 0 input, pin 0 enable, pin 0 output, pin 1 input, and so on, so the chain is 3×PIN_COUNT bits long.
- R4: With `clockEn`=0 the capture stages hold, whatever `shiftSel`, `scanIn` and the parallel inputs do.
- R5: Update registers change only on an edge with `updateEn`=1. While the chain shifts, the outputs in test mode stay at their previous values.
- R6: With `modeSel`=0 and `highZ`=0: `padOut`=`coreOut`, `padOe`=`coreOe` and `coreIn`=`padIn`.
- R7: With `modeSel`=1, `padOut[i]`, `padOe[i]` and `coreIn[i]` come from pin i's output, enable and input update registers.
- R8: `highZ`=1 forces `padOe` to all 0 in either mode. It leaves `padOut` and `coreIn` unchanged. The output enable is active high.
- R9: `scanOut` is the output-data capture stage of the last pin, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scanIn | input | 1 | Serial data into the group |
| scanOut | output | 1 | Serial data out of the group |
| shiftSel | input | 1 | 1 = shift, 0 = capture when `clockEn` is high |
| clockEn | input | 1 | Capture/shift strobe |
| updateEn | input | 1 | Update strobe |
| modeSel | input | 1 | 0 = functional, 1 = test |
| highZ | input | 1 | Forces all pad enables off |
| coreOut | input | PIN_COUNT | Core output data |
| coreOe | input | PIN_COUNT | Core output enable |
| coreIn | output | PIN_COUNT | Data seen by the core |
| padOut | output | PIN_COUNT | Data to the pad driver |
| padOe | output | PIN_COUNT | Pad driver enable |
| padIn | input | PIN_COUNT | Pad receiver value |

## Verification
The hardest condition to reach is the one where the update registers must not follow the chain while it shifts. The same bits would otherwise look correct once the update strobe arrives. The stimulus reaches it by running the whole sweep in test mode. It checks the outputs after every shift sequence and before each update pulse against the value loaded in the previous round. Idle cycles with a toggling `shiftSel` and changed parallel inputs are placed just before the update. Each of the 64 patterns is both captured and shifted out in order, and a different pattern is shifted in.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef struct packed {
    logic captureEn;  // load parallel inputs into stages
    logic shiftEn;    // move chain one place
    logic updateEn;   // copy stages to update registers
    logic testMode;   // outputs from update registers
    logic forceOff;   // pad enables off
  } scanStrobes_t;
endpackage

// File: rtl/bscanCtrl.sv
module bscanCtrl
  import bscan_pkg::*;
(
  input  logic         shiftSel,
  input  logic         clockEn,
  input  logic         updateEn,
  input  logic         modeSel,
  input  logic         highZ,
  output scanStrobes_t strobes
);
  always_comb begin
    strobes.captureEn = clockEn & ~shiftSel;
    strobes.shiftEn   = clockEn &  shiftSel;
    strobes.updateEn  = updateEn;
    strobes.testMode  = modeSel;
    strobes.forceOff  = highZ;
  end
endmodule

// File: rtl/bscanCellData.sv
module bscanCellData
  import bscan_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  scanStrobes_t strobes,
  input  logic         serialIn,
  output logic         serialOut,
  input  logic         coreOutBit,
  input  logic         coreOeBit,
  output logic         coreInBit,
  output logic         padOutBit,
  output logic         padOeBit,
  input  logic         padInBit
);
  logic capIn, capOe, capOut;
  logic updIn, updOe, updOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capIn <= 1'b0; capOe <= 1'b0; capOut <= 1'b0;
    end else if (strobes.captureEn) begin
      capIn <= padInBit; capOe <= coreOeBit; capOut <= coreOutBit;
    end else if (strobes.shiftEn) begin
      capIn <= serialIn; capOe <= capIn; capOut <= capOe;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updIn <= 1'b0; updOe <= 1'b0; updOut <= 1'b0;
    end else if (strobes.updateEn) begin
      updIn <= capIn; updOe <= capOe; updOut <= capOut;
    end
  end

  assign serialOut = capOut;
  assign padOutBit = strobes.testMode ? updOut : coreOutBit;
  assign coreInBit = strobes.testMode ? updIn  : padInBit;
  always_comb begin
    if (strobes.forceOff)      padOeBit = 1'b0;
    else if (strobes.testMode) padOeBit = updOe;
    else                       padOeBit = coreOeBit;
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureEn |=> (capIn == $past(padInBit) && capOe == $past(coreOeBit)
                           && capOut == $past(coreOutBit)));
  p_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |=> (capIn == $past(serialIn) && capOe == $past(capIn)
                         && capOut == $past(capOe)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.captureEn || strobes.shiftEn) |=> ($stable(capIn) && $stable(capOe) && $stable(capOut)));
  p_update_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.updateEn |=> ($stable(updIn) && $stable(updOe) && $stable(updOut)));
  p_update_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updateEn |=> (updOut == $past(capOut) && updOe == $past(capOe) && updIn == $past(capIn)));
endmodule

// File: rtl/bscanPinGroup.sv
module bscanPinGroup
  import bscan_pkg::*;
#(
  parameter int PIN_COUNT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 scanIn,
  output logic                 scanOut,
  input  logic                 shiftSel,
  input  logic                 clockEn,
  input  logic                 updateEn,
  input  logic                 modeSel,
  input  logic                 highZ,
  input  logic [PIN_COUNT-1:0] coreOut,
  input  logic [PIN_COUNT-1:0] coreOe,
  output logic [PIN_COUNT-1:0] coreIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PIN_COUNT-1:0] padIn
);
  localparam int LINK_COUNT = PIN_COUNT + 1;

  scanStrobes_t strobes;
  logic [LINK_COUNT-1:0] link;

  bscanCtrl uCtrl (
    .shiftSel(shiftSel), .clockEn(clockEn), .updateEn(updateEn),
    .modeSel(modeSel), .highZ(highZ), .strobes(strobes)
  );

  assign link[0] = scanIn;

  for (genvar i = 0; i < PIN_COUNT; i++) begin : gPin
    bscanCellData uCell (
      .clk(clk), .rstN(rstN), .strobes(strobes),
      .serialIn(link[i]), .serialOut(link[i+1]),
      .coreOutBit(coreOut[i]), .coreOeBit(coreOe[i]), .coreInBit(coreIn[i]),
      .padOutBit(padOut[i]), .padOeBit(padOe[i]), .padInBit(padIn[i])
    );
  end

  assign scanOut = link[PIN_COUNT];

  p_highz_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    highZ |-> (padOe == '0));
  p_func_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel && !highZ) |-> (padOut == coreOut && padOe == coreOe && coreIn == padIn));
endmodule

// File: tb/tb_bscanPinGroup.sv
module tb_bscanPinGroup;
  localparam int N = 2;
  localparam int L = 3 * N;

  logic clk = 1'b0, rstN = 1'b0;
  logic scanIn = 0, shiftSel = 0, clockEn = 0, updateEn = 0, modeSel = 0, highZ = 0;
  logic [N-1:0] coreOut = '0, coreOe = '0, padIn = '0;
  logic scanOut;
  logic [N-1:0] coreIn, padOut, padOe;

  int total = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bscanPinGroup #(.PIN_COUNT(N)) dut (
    .clk(clk), .rstN(rstN), .scanIn(scanIn), .scanOut(scanOut),
    .shiftSel(shiftSel), .clockEn(clockEn), .updateEn(updateEn),
    .modeSel(modeSel), .highZ(highZ), .coreOut(coreOut), .coreOe(coreOe),
    .coreIn(coreIn), .padOut(padOut), .padOe(padOe), .padIn(padIn)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  // stage k (0 = nearest scanIn) -> expected outputs from stage vector
  function automatic logic [5:0] outsOf(input logic [L-1:0] st);
    // packed as {padOut[1:0], padOe[1:0], coreIn[1:0]}
    return {st[5], st[2], st[4], st[1], st[3], st[0]};
  endfunction

  initial begin
    logic [L-1:0] cap, prevUpd;
    #1000000;
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] stg, sIn, prev;
    repeat (2) @(posedge clk);
    #2 rstN = 1'b1;
    modeSel = 1; #1;
    chk("R1 outputs", {padOut, padOe, coreIn}, 8'h0);
    chk("R1 scanOut", {7'b0, scanOut}, 8'h0);
    prev = '0;

    for (int p = 0; p < 64; p++) begin
      // functional passthrough
      modeSel = 0; highZ = 0;
      coreOut = p[1:0]; coreOe = p[3:2]; padIn = p[5:4];
      #1;
      chk("R6 padOut", {6'b0, padOut}, {6'b0, coreOut});
      chk("R6 padOe", {6'b0, padOe}, {6'b0, coreOe});
      chk("R6 coreIn", {6'b0, coreIn}, {6'b0, padIn});
      highZ = 1; #1;
      chk("R8 func padOe", {6'b0, padOe}, 8'h0);
      chk("R8 func padOut", {6'b0, padOut}, {6'b0, coreOut});
      highZ = 0;
      // capture
      stg = {coreOut[1], coreOe[1], padIn[1], coreOut[0], coreOe[0], padIn[0]};
      modeSel = 1;
      clockEn = 1; shiftSel = 0; tick();
      clockEn = 0;
      coreOut = ~coreOut; coreOe = ~coreOe; padIn = ~padIn;
      // shift out captured, shift in new
      sIn = 6'(p) ^ 6'h2A;
      for (int j = 0; j < L; j++) begin
        chk(j == 0 ? "R2 R9 captured bit" : "R3 shifted bit", {7'b0, scanOut}, {7'b0, stg[L-1-j]});
        scanIn = sIn[j]; shiftSel = 1; clockEn = 1; tick();
        clockEn = 0;
        chk("R5 stable while shifting", {2'b0, padOut, padOe, coreIn}, {2'b0, outsOf(prev)});
      end
      // idle with toggling controls: chain must hold
      for (int k = 0; k < 3; k++) begin
        shiftSel = k[0]; scanIn = ~scanIn; padIn = padIn + 1; coreOe = coreOe ^ 2'b01;
        tick();
      end
      for (int k = 0; k < L; k++) stg[k] = sIn[L-1-k];
      chk("R4 R9 hold then scanOut", {7'b0, scanOut}, {7'b0, stg[L-1]});
      chk("R5 before update", {2'b0, padOut, padOe, coreIn}, {2'b0, outsOf(prev)});
      updateEn = 1; tick(); updateEn = 0;
      chk("R7 test outputs", {2'b0, padOut, padOe, coreIn}, {2'b0, outsOf(stg)});
      highZ = 1; #1;
      chk("R8 test padOe", {6'b0, padOe}, 8'h0);
      chk("R8 test padOut", {6'b0, padOut}, {6'b0, stg[5], stg[2]});
      chk("R8 test coreIn", {6'b0, coreIn}, {6'b0, stg[3], stg[0]});
      highZ = 0;
      prev = stg;
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule